// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog that resets the chip when software stops servicing it or touches its registers in the wrong way. Two byte-wide registers sit on a small bus. One is a setup register that can be written only once after each reset. It picks the count source, from either a slow internal oscillator or the main clock, and it picks the overflow interval. The other is a restart register: writing the correct key clears the counter. Any other value, or any access flagged as a single-bit (read-modify-write) operation, counts as a violation.

A violation, a second setup write, or a counter overflow raises a one-cycle internal reset request. The surrounding logic is expected to feed that request back into the synchronous system reset, which returns every register to its reset value. Until software writes the setup register, the counter already runs on the slow source at the longest interval.

Top module: `wdt_guard`

## Requirements
- R1: A byte write of 0xAC to the restart register (address 0x11) with the bit flag low clears the counter, so the next overflow needs a full interval of ticks. If that write lands on the same edge as the terminal tick, the clear wins and no request is raised.
- R2: A byte write of any value other than 0xAC to the restart register raises `wdt_rst_req` in the cycle after the write.
- R3: A write to the restart register with `bus_bit` high raises `wdt_rst_req`, even when the data is 0xAC.
- R4: A read of the restart register always returns 0x9A on `bus_rdata` in the cycle after the read strobe, whatever was written before.
- R5: After reset, the setup register (address 0x10) accepts exactly one legal byte write. Any further write raises `wdt_rst_req` and leaves the stored value unchanged.
- R6: A write to the setup register with `bus_bit` high is ignored: the value stays and the register stays writable. The write still raises `wdt_rst_req`.
- R7: With the default `LOCK_SLOW=1`, bits [7:5] of the setup register always read as 011, whatever is written to them. With `LOCK_SLOW=0`, a write whose bits [7:5] are not 011 is illegal and raises `wdt_rst_req`.
- R8: Setup bit 4 picks the count source: 0 counts `slow_tick` pulses and 1 counts `main_tick` pulses. The source that is not selected has no effect.
- R9: Setup bits [2:0] = n set the interval. `wdt_rst_req` rises after the edge that carries the 2^(10+n)-th selected tick since the last clear. A legal setup write also clears the counter.
- R10: After reset, the setup register reads 0x67 (slow source, n=7), `wdt_rst_req` is low, and counting starts at once on the slow source.
- R11: `wdt_rst_req` is registered and lasts one cycle. When it is fed back as the system reset, all state returns to reset values and the setup register becomes writable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | Count enable from the slow internal oscillator |
| main_tick | input | 1 | Count enable from the main clock |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_bit | input | 1 | Marks the access as a single-bit (read-modify-write) operation |
| bus_rdata | output | 8 | Registered read data |
| wdt_rst_req | output | 1 | One-cycle internal reset request |

## Verification
The checker watches, on every cycle, the rules that link a bus access to its result one cycle later. These are: a wrong key or a flagged access to the restart register raises the request, the restart register reads back 0x9A, a key write clears the counter, setup writes after the lock raise the request, and flagged setup writes leave the value alone. It also checks that the upper setup bits stay fixed and that the request never lasts two cycles. Only the bench scenarios can show the interval lengths for each source and value of n, and the clear-versus-terminal race. They also show the long default interval after reset, and that the feedback reset really restores the setup register and its single write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] WDT_KEY      = 8'hAC;
  localparam logic [7:0] WDT_KEY_READ = 8'h9A;
  localparam logic [7:0] WDT_MODE_RST = 8'h67;
  localparam logic [2:0] WDT_UPPER    = 3'b011;
  localparam int         WDT_SRC_BIT  = 4;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int                 ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  MODE_ADDR = 'h10,
  parameter logic [ADDR_W-1:0]  KEY_ADDR  = 'h11,
  parameter bit                 LOCK_SLOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_bit,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        mode_q,
  output logic              mode_locked,
  output logic              cnt_clr,
  output logic              violation
);
  logic       mode_hit, key_hit, upper_ok;
  logic       mode_ok, mode_bad, key_ok, key_bad;
  logic [7:0] mode_next;

  assign mode_hit = bus_wr && (bus_addr == MODE_ADDR);
  assign key_hit  = bus_wr && (bus_addr == KEY_ADDR);

  generate
    if (LOCK_SLOW) begin : g_locked_src
      assign upper_ok  = 1'b1;
      assign mode_next = {WDT_UPPER, bus_wdata[4:0]};
    end else begin : g_free_src
      assign upper_ok  = (bus_wdata[7:5] == WDT_UPPER);
      assign mode_next = bus_wdata;
    end
  endgenerate

  assign mode_ok  = mode_hit && !bus_bit && !mode_locked && upper_ok;
  assign mode_bad = mode_hit && !mode_ok;
  assign key_ok   = key_hit && !bus_bit && (bus_wdata == WDT_KEY);
  assign key_bad  = key_hit && !key_ok;

  assign cnt_clr   = key_ok || mode_ok;
  assign violation = key_bad || mode_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= WDT_MODE_RST;
      mode_locked <= 1'b0;
      bus_rdata   <= 8'h00;
    end else begin
      if (mode_ok) begin
        mode_q      <= mode_next;
        mode_locked <= 1'b1;
      end
      if (bus_rd) begin
        if (bus_addr == KEY_ADDR)       bus_rdata <= WDT_KEY_READ;
        else if (bus_addr == MODE_ADDR) bus_rdata <= mode_q;
        else                            bus_rdata <= 8'h00;
      end
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int BASE_EXP = 10,
  parameter int SEL_W    = 3,
  localparam int CNT_W   = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_tick,
  input  logic             main_tick,
  input  logic             use_main,
  input  logic [SEL_W-1:0] sel,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic             tick;
  logic [CNT_W:0]   lim, lim_m1;
  logic [CNT_W-1:0] term;

  assign tick   = use_main ? main_tick : slow_tick;
  assign lim    = {{CNT_W{1'b0}}, 1'b1} << (BASE_EXP + int'(sel));
  assign lim_m1 = lim - 1'b1;
  assign term   = lim_m1[CNT_W-1:0];
  assign ovf    = tick && !clr && (cnt == term);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= ovf ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 'h11,
  parameter int                BASE_EXP  = 10,
  parameter int                SEL_W     = 3,
  parameter bit                LOCK_SLOW = 1'b1,
  localparam int               CNT_W     = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              main_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_bit,
  output logic [7:0]        bus_rdata,
  output logic              wdt_rst_req
);
  logic [7:0]       mode_q;
  logic             mode_locked, cnt_clr, violation, ovf;
  logic [CNT_W-1:0] cnt_val;

  wdt_regs #(
    .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .KEY_ADDR(KEY_ADDR), .LOCK_SLOW(LOCK_SLOW)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_bit(bus_bit), .bus_rdata(bus_rdata),
    .mode_q(mode_q), .mode_locked(mode_locked), .cnt_clr(cnt_clr), .violation(violation)
  );

  wdt_counter #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .main_tick(main_tick),
    .use_main(mode_q[WDT_SRC_BIT]), .sel(mode_q[SEL_W-1:0]),
    .clr(cnt_clr), .cnt(cnt_val), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) wdt_rst_req <= 1'b0;
    else     wdt_rst_req <= violation || ovf;
  end
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
  import wdt_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 'h11,
  parameter bit                LOCK_SLOW = 1'b1,
  parameter int                CNT_W     = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic              bus_bit,
  input logic [7:0]        bus_rdata,
  input logic              wdt_rst_req,
  input logic [7:0]        mode_q,
  input logic              locked,
  input logic [CNT_W-1:0]  cnt
);
  logic key_wr, mode_wr;
  assign key_wr  = bus_wr && (bus_addr == KEY_ADDR);
  assign mode_wr = bus_wr && (bus_addr == MODE_ADDR);

  AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    key_wr && !bus_bit && bus_wdata == WDT_KEY |=> cnt == '0); // R1
  AST_WRONG_KEY: assert property (@(posedge clk) disable iff (rst)
    key_wr && bus_wdata != WDT_KEY |=> wdt_rst_req); // R2
  AST_BIT_KEY: assert property (@(posedge clk) disable iff (rst)
    key_wr && bus_bit |=> wdt_rst_req); // R3
  AST_KEY_READ: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == KEY_ADDR |=> bus_rdata == WDT_KEY_READ); // R4
  AST_SECOND_SETUP: assert property (@(posedge clk) disable iff (rst)
    mode_wr && locked |=> wdt_rst_req && mode_q == $past(mode_q)); // R5
  AST_BIT_SETUP: assert property (@(posedge clk) disable iff (rst)
    mode_wr && bus_bit |=> wdt_rst_req && mode_q == $past(mode_q)); // R6
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_req |=> !wdt_rst_req); // R11

  generate
    if (LOCK_SLOW) begin : g_upper
      AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> mode_q[7:5] == WDT_UPPER); // R7
    end
  endgenerate
endmodule

bind wdt_guard wdt_guard_chk #(
  .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .KEY_ADDR(KEY_ADDR),
  .LOCK_SLOW(LOCK_SLOW), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_bit(bus_bit), .bus_rdata(bus_rdata),
  .wdt_rst_req(wdt_rst_req), .mode_q(mode_q), .locked(mode_locked), .cnt(cnt_val)
);

// File: tb/test_wdt_guard.sv
module test_wdt_guard;
  logic       clk = 1'b0;
  logic       ext_rst = 1'b1;
  logic       loop_en = 1'b1;
  logic       slow_tick = 1'b0, main_tick = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_bit = 1'b0;
  logic [7:0] bus_rdata;
  logic       wdt_rst_req;
  logic       rst;
  int         n_tests = 0, n_fail = 0;

  localparam logic [7:0] A_MODE = 8'h10;
  localparam logic [7:0] A_KEY  = 8'h11;

  assign rst = ext_rst || (loop_en && wdt_rst_req);

  always #5 clk = ~clk;

  wdt_guard i_wdt_guard (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .main_tick(main_tick),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_bit(bus_bit), .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic slow_v, input logic main_v);
    ext_rst = 1'b1;
    loop_en = 1'b1;
    slow_tick = slow_v;
    main_tick = main_v;
    repeat (3) @(negedge clk);
    ext_rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic b);
    bus_addr = a; bus_wdata = d; bus_bit = b; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_bit = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [7:0] d;
    do_reset(1'b0, 1'b0);
    check("R10 req after reset", wdt_rst_req, 0);
    rd(A_KEY, d);  check("R4 restart readback", d, 8'h9A);
    rd(A_MODE, d); check("R10 setup reset value", d, 8'h67);
  endtask

  task automatic t_interval(input logic [7:0] setup, input int edges, input string tag);
    do_reset(1'b0, 1'b1);
    wr(A_MODE, setup, 1'b0);
    check({tag, " no req on setup write"}, wdt_rst_req, 0);
    wait_edges(edges - 1);
    check({tag, " quiet before terminal"}, wdt_rst_req, 0);
    wait_edges(1);
    check({tag, " req at terminal"}, wdt_rst_req, 1);
    wait_edges(1);
  endtask

  task automatic t_source;
    logic [7:0] d;
    do_reset(1'b0, 1'b1);
    wr(A_MODE, 8'h60, 1'b0);
    wait_edges(2000);
    rd(A_MODE, d);
    check("R8 main ticks ignored on slow source", d, 8'h60);
    slow_tick = 1'b1;
    wait_edges(1023);
    check("R8 slow source quiet", wdt_rst_req, 0);
    wait_edges(1);
    check("R8 slow source overflow", wdt_rst_req, 1);
    wait_edges(1);
  endtask

  task automatic t_key_restart;
    do_reset(1'b0, 1'b1);
    wr(A_MODE, 8'h70, 1'b0);
    wait_edges(1000);
    wr(A_KEY, 8'hAC, 1'b0);
    check("R1 key gives no req", wdt_rst_req, 0);
    wait_edges(1023);
    check("R1 full interval after key", wdt_rst_req, 0);
    wait_edges(1);
    check("R1 overflow after key", wdt_rst_req, 1);
    wait_edges(1);
  endtask

  task automatic t_key_race;
    do_reset(1'b0, 1'b1);
    wr(A_MODE, 8'h70, 1'b0);
    wait_edges(1023);
    wr(A_KEY, 8'hAC, 1'b0);
    check("R1 key beats terminal tick", wdt_rst_req, 0);
    wait_edges(1023);
    check("R1 race quiet", wdt_rst_req, 0);
    wait_edges(1);
    check("R1 race overflow", wdt_rst_req, 1);
    wait_edges(1);
  endtask

  task automatic t_bad_key;
    logic [7:0] d;
    do_reset(1'b0, 1'b0);
    wr(A_MODE, 8'h72, 1'b0);
    wr(A_KEY, 8'h55, 1'b0);
    check("R2 wrong key req", wdt_rst_req, 1);
    wait_edges(1);
    check("R11 req single cycle", wdt_rst_req, 0);
    rd(A_MODE, d);
    check("R11 setup restored", d, 8'h67);
    wr(A_MODE, 8'h72, 1'b0);
    check("R11 setup writable again", wdt_rst_req, 0);
    rd(A_MODE, d);
    check("R11 rewrite stored", d, 8'h72);
  endtask

  task automatic t_bit_key;
    do_reset(1'b0, 1'b0);
    wr(A_KEY, 8'hAC, 1'b1);
    check("R3 bit access to restart", wdt_rst_req, 1);
    wait_edges(1);
  endtask

  task automatic t_key_readback;
    logic [7:0] d;
    do_reset(1'b0, 1'b0);
    wr(A_KEY, 8'hAC, 1'b0);
    rd(A_KEY, d);
    check("R4 readback after key", d, 8'h9A);
  endtask

  task automatic t_second_setup;
    logic [7:0] d;
    do_reset(1'b0, 1'b0);
    loop_en = 1'b0;
    wr(A_MODE, 8'h63, 1'b0);
    check("R5 first setup accepted", wdt_rst_req, 0);
    wr(A_MODE, 8'h75, 1'b0);
    check("R5 second setup req", wdt_rst_req, 1);
    rd(A_MODE, d);
    check("R5 value kept", d, 8'h63);
    loop_en = 1'b1;
  endtask

  task automatic t_bit_setup;
    logic [7:0] d;
    do_reset(1'b0, 1'b0);
    loop_en = 1'b0;
    wr(A_MODE, 8'h74, 1'b1);
    check("R6 bit setup req", wdt_rst_req, 1);
    rd(A_MODE, d);
    check("R6 bit setup ignored", d, 8'h67);
    wr(A_MODE, 8'h74, 1'b0);
    check("R6 still writable", wdt_rst_req, 0);
    rd(A_MODE, d);
    check("R6 byte write stored", d, 8'h74);
    loop_en = 1'b1;
  endtask

  task automatic t_upper;
    logic [7:0] d;
    do_reset(1'b0, 1'b0);
    wr(A_MODE, 8'h15, 1'b0);
    check("R7 upper bits no req", wdt_rst_req, 0);
    rd(A_MODE, d);
    check("R7 upper bits forced", d, 8'h75);
    do_reset(1'b0, 1'b0);
    wr(A_MODE, 8'hE2, 1'b0);
    rd(A_MODE, d);
    check("R7 upper bits forced again", d, 8'h62);
  endtask

  task automatic t_default_run;
    do_reset(1'b1, 1'b0);
    wait_edges(131071);
    check("R10 default interval quiet", wdt_rst_req, 0);
    wait_edges(1);
    check("R10 default interval overflow", wdt_rst_req, 1);
    wait_edges(1);
    slow_tick = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_interval(8'h70, 1024, "R9 n0");
    t_interval(8'h71, 2048, "R9 n1");
    t_source();
    t_key_restart();
    t_key_race();
    t_bad_key();
    t_bit_key();
    t_key_readback();
    t_second_setup();
    t_bit_setup();
    t_upper();
    t_default_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule